// File: doc/BRIEF.md
# Interleaved Banked Vector Load Memory

This block feeds a vector load unit from a word memory split across eight interleaved banks. A single start pulse supplies a base word address, a stride and an element count. The block then walks the address sequence one element per cycle. Each element goes to the bank named by the low three address bits. A bank that has just been accessed stays occupied for six cycles, and during that time it cannot take another access.

When the next element in the sequence maps to an occupied bank, issue stops at that element until the bank frees up. Later elements are never reordered around it. Every bank has the same fixed latency, so elements come back in index order. They leave through a write port that carries the compact destination index and the data word, ready to be written into a vector register.

A unit stride, or any stride coprime with eight, spreads the accesses over all banks, so one element issues every cycle. A stride that is a multiple of eight sends every access to one bank, and each element then costs the full bank time. Bank contents are a fixed pattern computed from the address.

Top module: `vmem_banked_load`

## Requirements
- R1: Out of reset, busy_o, wr_valid_o and done_o are all low.
- R2: Element i reads word address (base_i + i*stride_i) mod 128. The bank is address bits [2:0] and the row within the bank is bits [6:3]. The word stored at address a is {u, ~u} with u = 32'h5A00_0000 + a (u in bits 63:32).
- R3: Each element appears on the write port exactly once, in increasing index order, with wr_idx_o = i. At most one element appears per cycle.
- R4: A bank accessed at clock edge t cannot be accessed again before edge t+6. The data for that access is presented on the write port in the cycle after edge t+5.
- R5: The first element issues at the first edge after the start edge. Each later element issues at the earliest edge that is both after the previous issue and permitted by R4 for its bank. An element waiting on a busy bank holds back every later element.
- R6: With stride 1 (or any odd stride) the last element is presented n+5 edges after the start edge. With a stride that is a multiple of 8 it is presented 6n edges after.
- R7: A start_i pulse while busy_o is high is ignored. The running vector completes unchanged and no extra elements appear.
- R8: A start_i pulse with vlen_i = 0 is ignored. busy_o stays low and no element appears.
- R9: done_o is high for exactly one cycle per vector, in the same cycle as the last element (index vlen_i-1). busy_o is low from the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a vector load (taken only when idle and vlen_i is nonzero) |
| base_i | input | 7 | Word address of element 0 |
| stride_i | input | 7 | Address step between elements, modulo 128 |
| vlen_i | input | 7 | Element count, 0 to 64 |
| busy_o | output | 1 | Vector load in progress |
| wr_valid_o | output | 1 | Write port holds a returned element |
| wr_idx_o | output | 6 | Destination index of the returned element |
| wr_data_o | output | 64 | Returned data word |
| done_o | output | 1 | Pulse with the last returned element |

## Verification
The hardest case is a stall pattern where only some banks collide. An example is stride 2 or 4, where groups of elements issue back to back and then wait for the bank used one group earlier. Another is an address sequence that wraps past the top of memory partway through a vector. The bench computes the exact issue edge of every element from the bank-occupancy rule and checks the total completion time. It runs strides 0, 1, 2, 3, 4, 5 and 8, a wrapping base and the full 64-element length. A second start pulse is also fired into a running vector to confirm that no stray elements leak onto the write port.

// File: rtl/vmem_pkg.sv
package vmem_pkg;
  localparam int NUM_BANKS = 8;
  localparam int BANK_CYC  = 6;
  localparam int MAX_VL    = 64;
  localparam int DATA_W    = 64;
  localparam int ADDR_W    = 7;

  // fixed memory image: upper half is a marker plus address, lower half its inverse
  function automatic logic [63:0] init_word(input int unsigned a);
    logic [31:0] u;
    u = 32'h5A00_0000 + a;
    return {u, ~u};
  endfunction
endpackage

// File: rtl/vmem_bank.sv
module vmem_bank #(
  parameter int NUM_BANKS = 8,
  parameter int BANK_ID   = 0,
  parameter int ROW_W     = 4,
  parameter int IDX_W     = 6,
  parameter int DATA_W    = 64,
  parameter int BANK_CYC  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              iss_i,
  input  logic [ROW_W-1:0]  row_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic              free_o,
  output logic              ret_valid_o,
  output logic [IDX_W-1:0]  ret_idx_o,
  output logic [DATA_W-1:0] ret_data_o
);
  localparam int ROWS  = 1 << ROW_W;
  localparam int CNT_W = $clog2(BANK_CYC + 1);

  logic [DATA_W-1:0] mem [ROWS];
  logic [CNT_W-1:0]  cnt_q;
  logic              ret_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] data_q;

  always_comb begin
    for (int r = 0; r < ROWS; r++)
      mem[r] = DATA_W'(vmem_pkg::init_word(r * NUM_BANKS + BANK_ID));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      ret_q  <= 1'b0;
      idx_q  <= '0;
      data_q <= '0;
    end else begin
      ret_q <= (cnt_q == CNT_W'(1));
      if (iss_i) begin
        cnt_q  <= CNT_W'(BANK_CYC - 1);
        idx_q  <= idx_i;
        data_q <= mem[row_i];
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign free_o      = (cnt_q == '0);
  assign ret_valid_o = ret_q;
  assign ret_idx_o   = idx_q;
  assign ret_data_o  = data_q;

  a_r4_no_issue_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iss_i |-> free_o);
  a_r4_busy_after_issue: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iss_i |=> !free_o);
endmodule

// File: rtl/vmem_issue.sv
module vmem_issue #(
  parameter int NUM_BANKS = 8,
  parameter int ADDR_W    = 7,
  parameter int LEN_W     = 7,
  parameter int IDX_W     = 6
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic [ADDR_W-1:0]       base_i,
  input  logic [ADDR_W-1:0]       stride_i,
  input  logic [LEN_W-1:0]        vlen_i,
  input  logic [NUM_BANKS-1:0]    bank_free_i,
  input  logic                    ret_valid_i,
  input  logic [IDX_W-1:0]        ret_idx_i,
  output logic                    iss_valid_o,
  output logic [$clog2(NUM_BANKS)-1:0] iss_bank_o,
  output logic [ADDR_W-$clog2(NUM_BANKS)-1:0] iss_row_o,
  output logic [IDX_W-1:0]        iss_idx_o,
  output logic                    active_o,
  output logic                    done_o
);
  localparam int BANK_W = $clog2(NUM_BANKS);

  logic              active_q;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] stride_q;
  logic [LEN_W-1:0]  vlen_q;
  logic [LEN_W-1:0]  idx_q;
  logic              issue;

  assign iss_bank_o  = addr_q[BANK_W-1:0];
  assign iss_row_o   = addr_q[ADDR_W-1:BANK_W];
  assign iss_idx_o   = idx_q[IDX_W-1:0];
  // in-order: a stalled element blocks all later ones
  assign issue       = active_q && (idx_q != vlen_q) && bank_free_i[iss_bank_o];
  assign iss_valid_o = issue;
  assign done_o      = active_q && ret_valid_i && (LEN_W'(ret_idx_i) == vlen_q - 1'b1);
  assign active_o    = active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      addr_q   <= '0;
      stride_q <= '0;
      vlen_q   <= '0;
      idx_q    <= '0;
    end else if (!active_q) begin
      if (start_i && vlen_i != '0) begin
        active_q <= 1'b1;
        addr_q   <= base_i;
        stride_q <= stride_i;
        vlen_q   <= vlen_i;
        idx_q    <= '0;
      end
    end else begin
      if (issue) begin
        addr_q <= addr_q + stride_q;
        idx_q  <= idx_q + 1'b1;
      end
      if (done_o) active_q <= 1'b0;
    end
  end

  a_r5_idx_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q |-> idx_q <= vlen_q);
  a_r5_idle_no_issue: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_q |-> !iss_valid_o);
endmodule

// File: rtl/vmem_banked_load.sv
module vmem_banked_load #(
  parameter int NUM_BANKS = vmem_pkg::NUM_BANKS,
  parameter int BANK_CYC  = vmem_pkg::BANK_CYC,
  parameter int MAX_VL    = vmem_pkg::MAX_VL,
  parameter int DATA_W    = vmem_pkg::DATA_W,
  parameter int ADDR_W    = vmem_pkg::ADDR_W,
  localparam int LEN_W    = $clog2(MAX_VL + 1),
  localparam int IDX_W    = $clog2(MAX_VL)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] stride_i,
  input  logic [LEN_W-1:0]  vlen_i,
  output logic              busy_o,
  output logic              wr_valid_o,
  output logic [IDX_W-1:0]  wr_idx_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              done_o
);
  localparam int BANK_W = $clog2(NUM_BANKS);
  localparam int ROW_W  = ADDR_W - BANK_W;

  logic [NUM_BANKS-1:0] bank_free;
  logic [NUM_BANKS-1:0] ret_v;
  logic [IDX_W-1:0]     ret_idx  [NUM_BANKS];
  logic [DATA_W-1:0]    ret_data [NUM_BANKS];
  logic                 iss_valid;
  logic [BANK_W-1:0]    iss_bank;
  logic [ROW_W-1:0]     iss_row;
  logic [IDX_W-1:0]     iss_idx;

  vmem_issue #(
    .NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W), .LEN_W(LEN_W), .IDX_W(IDX_W)
  ) u_issue (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .base_i     (base_i),
    .stride_i   (stride_i),
    .vlen_i     (vlen_i),
    .bank_free_i(bank_free),
    .ret_valid_i(wr_valid_o),
    .ret_idx_i  (wr_idx_o),
    .iss_valid_o(iss_valid),
    .iss_bank_o (iss_bank),
    .iss_row_o  (iss_row),
    .iss_idx_o  (iss_idx),
    .active_o   (busy_o),
    .done_o     (done_o)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    vmem_bank #(
      .NUM_BANKS(NUM_BANKS), .BANK_ID(b), .ROW_W(ROW_W),
      .IDX_W(IDX_W), .DATA_W(DATA_W), .BANK_CYC(BANK_CYC)
    ) u_bank (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .iss_i      (iss_valid && iss_bank == BANK_W'(b)),
      .row_i      (iss_row),
      .idx_i      (iss_idx),
      .free_o     (bank_free[b]),
      .ret_valid_o(ret_v[b]),
      .ret_idx_o  (ret_idx[b]),
      .ret_data_o (ret_data[b])
    );
  end

  // fixed latency + single issue per cycle -> at most one bank returns
  always_comb begin
    wr_valid_o = 1'b0;
    wr_idx_o   = '0;
    wr_data_o  = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (ret_v[b]) begin
        wr_valid_o = 1'b1;
        wr_idx_o   = ret_idx[b];
        wr_data_o  = ret_data[b];
      end
    end
  end

  a_r3_one_return: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ret_v));
  a_r9_done_clears_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);
  a_r9_done_with_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> wr_valid_o);
endmodule

// File: tb/vmem_banked_load_bench.sv
module vmem_banked_load_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [6:0]  base = '0, stride = '0, vlen = '0;
  logic        busy, wr_valid, done;
  logic [5:0]  wr_idx;
  logic [63:0] wr_data;

  int tests = 0, fails = 0;
  int cyc = 0, done_cnt = 0, done_cyc = 0;
  logic [63:0] exp_data[$];
  int          exp_idx[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc++;

  vmem_banked_load u_vmem_banked_load (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .base_i(base),
    .stride_i(stride), .vlen_i(vlen), .busy_o(busy), .wr_valid_o(wr_valid),
    .wr_idx_o(wr_idx), .wr_data_o(wr_data), .done_o(done)
  );

  function automatic logic [63:0] word_at(int a);
    logic [31:0] u;
    u = 32'h5A00_0000 + a;
    return {u, ~u};
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // scoreboard monitor (R2, R3)
  always @(negedge clk) if (rst_n) begin
    if (wr_valid) begin
      if (exp_data.size() == 0) begin
        check(0, "R3/R7 unexpected write", wr_idx, -1);
      end else begin
        logic [63:0] ed;
        int ei;
        ed = exp_data.pop_front();
        ei = exp_idx.pop_front();
        check(wr_idx == 6'(ei), "R3 index order", wr_idx, ei);
        check(wr_data == ed, "R2 data word", wr_data, ed);
      end
    end
    if (done) begin
      done_cnt++;
      done_cyc = cyc;
    end
  end

  task automatic run_vec(input int b, input int s, input int n, input bit intrude, input string req);
    int bank_last[8];
    int t_prev, t_last, c0, guard;
    for (int k = 0; k < 8; k++) bank_last[k] = -100;
    t_prev = 0;
    t_last = 0;
    for (int i = 0; i < n; i++) begin
      int a, t;
      a = (b + i * s) % 128;
      t = t_prev + 1;
      if (bank_last[a % 8] + 6 > t) t = bank_last[a % 8] + 6;
      bank_last[a % 8] = t;
      t_prev = t;
      t_last = t;
      exp_data.push_back(word_at(a));
      exp_idx.push_back(i);
    end
    done_cnt = 0;
    @(negedge clk);
    start = 1'b1; base = 7'(b); stride = 7'(s); vlen = 7'(n);
    c0 = cyc;
    @(negedge clk);
    start = 1'b0;
    if (intrude) begin
      repeat (2) @(negedge clk);
      start = 1'b1; base = 7'd9; stride = 7'd1; vlen = 7'd4;
      @(negedge clk);
      start = 1'b0;
    end
    guard = 0;
    while (done_cnt == 0 && guard < 2000) begin
      @(posedge clk);
      guard++;
    end
    @(negedge clk);
    check(done_cnt == 1, {req, " done seen"}, done_cnt, 1);
    check(done_cyc - (c0 + 1) == t_last + 5, {req, " completion edges"},
          done_cyc - (c0 + 1), t_last + 5);
    check(exp_data.size() == 0, "R3 all elements returned", exp_data.size(), 0);
    check(!busy, "R9 busy cleared after done", busy, 0);
    repeat (8) @(negedge clk);
    check(done_cnt == 1, "R9 single done pulse", done_cnt, 1);
    exp_data.delete();
    exp_idx.delete();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !wr_valid && !done, "R1 reset outputs", {busy, wr_valid, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy, "R1 idle after reset", busy, 0);

    run_vec(0, 1, 16, 0, "R6 R5 unit stride");     // n+5 = 21
    run_vec(3, 8, 5, 0, "R6 R4 stride 8");         // 6n = 30
    run_vec(0, 2, 8, 0, "R5 stride 2");
    run_vec(1, 4, 6, 0, "R4 stride 4");
    run_vec(17, 0, 3, 0, "R4 stride 0");
    run_vec(120, 5, 10, 0, "R2 address wrap");
    run_vec(2, 3, 20, 0, "R6 odd stride");
    run_vec(0, 1, 64, 0, "R3 max length");
    run_vec(77, 1, 1, 0, "R9 single element");
    run_vec(4, 8, 4, 1, "R7 start while busy");

    // R8: zero length start is ignored
    done_cnt = 0;
    @(negedge clk);
    start = 1'b1; base = 7'd5; stride = 7'd1; vlen = 7'd0;
    @(negedge clk);
    start = 1'b0;
    check(!busy, "R8 zero length ignored", busy, 0);
    repeat (10) @(negedge clk);
    check(done_cnt == 0, "R8 no done for zero length", done_cnt, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule